// File: doc/BRIEF.md
# Super I/O Configuration Register Port

This block is the configuration front end of a legacy-PC peripheral chip. It answers a byte-wide I/O bus at two consecutive addresses. The even address is an index port that selects one of the internal registers. The odd address is a data port that reads or writes the selected register. Three 8-bit registers are held:

- a function-enable register at index 0,
- a function-address register at index 1,
- a power/test register at index 2.

Their reset contents are chosen by a 5-bit strap input. After reset, the first two reads of the index port return a chip signature before they fall back to showing the selected index.

The register contents are decoded continuously into per-function outputs for the bus decoders of the sub-devices. These cover a parallel port, two UARTs, a floppy controller and an IDE controller. Each function gets an enable, an I/O base address and an interrupt number.

Setting the configuration-lock bit in the power/test register freezes all three registers until the next reset.

Top module: `sio_cfg_port`

## Requirements
- R1: Only two addresses are decoded: the index port at `BASE_ADDR` (default 0x398) and the data port at `BASE_ADDR`+1, with address bit 0 choosing between them. Writes to any other address change nothing, and `io_rdata` is 0 whenever no decoded read is active.
- R2: After reset, the first index-port read returns 0x88 and the second returns 0x00. Every later index read returns the selected index. Any index-port write stores the new index and ends the signature sequence at once.
- R3: Read data is combinational in the cycle `io_rd` is high. The signature sequence advances once per read strobe, at the first clock edge of the strobe, however long the strobe is held.
- R4: Reset selects index 0 and loads the three registers from tables addressed by `strap_cfg`. For example, strap 1 gives enable 0x4F, address 0x11, power 0x00; strap 12 gives 0x0F, 0x10, 0x00; strap 31 gives 0x00, 0x10, 0x02.
- R5: A data write updates the selected register only when the index is 0, 1 or 2. With any other index, a data write changes no register and a data read returns 0.
- R6: Once bit 6 of the power/test register holds 1, all further data-port writes are ignored until reset. Index writes still work.
- R7: The function-enable register decodes as follows: bit 0 enables the parallel port, bit 1 UART0, bit 2 UART1, bit 3 the floppy controller, and bit 6 the IDE controller.
- R8: The parallel port uses address-register bits [1:0].
  - Code 0 gives base 0x378, with IRQ 7 if power bit 3 is set and IRQ 5 otherwise.
  - Code 1 gives base 0x3BC with IRQ 7.
  - Code 2 gives base 0x278 with IRQ 5.
  - Code 3 gives base 0 with IRQ 0.
- R9: UART n uses address-register bits [2n+3:2n+2]. Code 0 gives base 0x3F8 and code 1 gives 0x2F8. For codes 2 and 3, address-register bits [7:6] pick the base:
  - code 2 uses the list 0x3E8, 0x338, 0x2E8, 0x220;
  - code 3 uses the list 0x2E8, 0x238, 0x2E0, 0x228.
- R10: A UART's IRQ is 3 when its code is odd and 4 when its code is even.
- R11: The floppy base is 0x370 when enable bit 5 is set and 0x3F0 otherwise, with IRQ 6. The IDE base is 0x170 when enable bit 7 is set and 0x1F0 otherwise. The IDE alternate base is the IDE base plus 0x206, and the IDE IRQ is 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_cfg | input | 5 | Strap value that selects the reset contents |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while `io_rd` is high |
| par_en | output | 1 | Parallel port enable |
| par_base | output | 16 | Parallel port base address |
| par_irq | output | 4 | Parallel port IRQ |
| uart_en | output | 2 | UART enables, bit n for UART n |
| uart_base | output | 32 | UART bases, UART n in bits [16n+15:16n] |
| uart_irq | output | 8 | UART IRQs, UART n in bits [4n+3:4n] |
| fdc_en | output | 1 | Floppy controller enable |
| fdc_base | output | 16 | Floppy controller base address |
| fdc_irq | output | 4 | Floppy controller IRQ |
| ide_en | output | 1 | IDE controller enable |
| ide_base | output | 16 | IDE command block base address |
| ide_alt_base | output | 16 | IDE alternate status base address |
| ide_irq | output | 4 | IDE controller IRQ |

## Verification
The bench holds a read strobe on the index port for several cycles and then reads again. A design that advanced the signature on every clock instead of on every strobe would skip the 0x00 byte. It also writes and reads through an index above 2: a design that wrapped the index onto a real register would corrupt that register, and one that did not zero the read would return stale data. Every address-register value is swept, so a misplaced UART field or a wrong alternate-bank table entry shows up as a wrong base. The lock test writes to all three registers after locking, which catches a lock that guards only some of them or that clears itself.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int IO_AW    = 16;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 3;
  localparam int NUM_UART = 2;
  localparam int IRQ_W    = 4;

  localparam logic [REG_W-1:0] SIG_FIRST  = 8'h88;
  localparam logic [REG_W-1:0] SIG_SECOND = 8'h00;
  localparam logic [IRQ_W-1:0] FDC_IRQ_NUM = 4'd6;
  localparam logic [IRQ_W-1:0] IDE_IRQ_NUM = 4'd14;
  localparam int LOCK_BIT = 6;

  typedef enum logic [1:0] {
    SIG_STEP_A = 2'd0,
    SIG_STEP_B = 2'd1,
    SIG_OVER   = 2'd2
  } sig_step_e;

  typedef struct packed {
    logic [REG_W-1:0] pwr;
    logic [REG_W-1:0] fadr;
    logic [REG_W-1:0] fen;
  } cfg_regs_t;

  function automatic logic [REG_W-1:0] fen_init(input logic [4:0] s);
    if (s <= 5'd5)       return 8'h4F;
    else if (s <= 5'd11) return 8'h4B;
    else if (s <= 5'd15) return 8'h0F;
    else if (s <= 5'd19) return 8'h49;
    else if (s <= 5'd23) return 8'h07;
    else if (s <= 5'd29) return 8'h47;
    else if (s == 5'd30) return 8'h08;
    else                 return 8'h00;
  endfunction

  function automatic logic [REG_W-1:0] fadr_init(input logic [4:0] s);
    case (s)
      5'd0, 5'd12, 5'd20, 5'd24, 5'd30, 5'd31:         return 8'h10;
      5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26:          return 8'h11;
      5'd3, 5'd14, 5'd22, 5'd27:                       return 8'h39;
      5'd4, 5'd15, 5'd23, 5'd28:                       return 8'h24;
      5'd5, 5'd29:                                     return 8'h38;
      5'd7, 5'd8, 5'd17, 5'd18:                        return 8'h01;
      5'd9:                                            return 8'h09;
      5'd10, 5'd11:                                    return 8'h08;
      default:                                         return 8'h00;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] pwr_init(input logic [4:0] s);
    return (s == 5'd31) ? 8'h02 : 8'h00;
  endfunction

endpackage

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       strap_cfg,
  input  logic             idx_wr,
  input  logic             dat_wr,
  input  logic             idx_rd,
  input  logic             dat_rd,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output cfg_regs_t        cfg_q,
  output logic [REG_W-1:0] sel_q,
  output sig_step_e        step_q
);

  localparam logic [REG_W-1:0] REG_LIMIT = REG_W'(NUM_REGS);

  cfg_regs_t        cfg_d;
  logic [REG_W-1:0] sel_d;
  sig_step_e        step_d;
  logic             rd_seen_q;
  logic             rd_rise;
  logic             sel_valid;
  logic             locked;
  logic             upd_en;

  assign rd_rise   = idx_rd & ~rd_seen_q;
  assign sel_valid = (sel_q < REG_LIMIT);
  assign locked    = cfg_q.pwr[LOCK_BIT];
  assign upd_en    = idx_wr | dat_wr | rd_rise;

  always_comb begin
    cfg_d  = cfg_q;
    sel_d  = sel_q;
    step_d = step_q;
    if (idx_wr) begin
      sel_d  = wdata;
      step_d = SIG_OVER;
    end else if (rd_rise) begin
      case (step_q)
        SIG_STEP_A: step_d = SIG_STEP_B;
        default:    step_d = SIG_OVER;
      endcase
    end
    if (dat_wr && sel_valid && !locked) begin
      case (sel_q[1:0])
        2'd0:    cfg_d.fen  = wdata;
        2'd1:    cfg_d.fadr = wdata;
        default: cfg_d.pwr  = wdata;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (dat_rd) begin
      if (sel_valid) begin
        case (sel_q[1:0])
          2'd0:    rdata = cfg_q.fen;
          2'd1:    rdata = cfg_q.fadr;
          default: rdata = cfg_q.pwr;
        endcase
      end
    end else if (idx_rd) begin
      case (step_q)
        SIG_STEP_A: rdata = SIG_FIRST;
        SIG_STEP_B: rdata = SIG_SECOND;
        default:    rdata = sel_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{pwr: pwr_init(strap_cfg), fadr: fadr_init(strap_cfg), fen: fen_init(strap_cfg)};
      sel_q  <= '0;
      step_q <= SIG_STEP_A;
    end else if (upd_en) begin
      cfg_q  <= cfg_d;
      sel_q  <= sel_d;
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_seen_q <= 1'b0;
    else        rd_seen_q <= idx_rd;
  end

endmodule

// File: rtl/sio_uart_map.sv
module sio_uart_map
  import sio_cfg_pkg::*;
(
  input  logic [1:0]       sel_code,
  input  logic [1:0]       bank,
  output logic [IO_AW-1:0] base,
  output logic [IRQ_W-1:0] irq
);

  always_comb begin
    case (sel_code)
      2'd0: base = 16'h03F8;
      2'd1: base = 16'h02F8;
      2'd2: begin
        case (bank)
          2'd0:    base = 16'h03E8;
          2'd1:    base = 16'h0338;
          2'd2:    base = 16'h02E8;
          default: base = 16'h0220;
        endcase
      end
      default: begin
        case (bank)
          2'd0:    base = 16'h02E8;
          2'd1:    base = 16'h0238;
          2'd2:    base = 16'h02E0;
          default: base = 16'h0228;
        endcase
      end
    endcase
    irq = sel_code[0] ? 4'd3 : 4'd4;
  end

endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
  import sio_cfg_pkg::*;
(
  input  cfg_regs_t                 cfg,
  output logic                      par_en,
  output logic [IO_AW-1:0]          par_base,
  output logic [IRQ_W-1:0]          par_irq,
  output logic [NUM_UART-1:0]       uart_en,
  output logic [NUM_UART*IO_AW-1:0] uart_base,
  output logic [NUM_UART*IRQ_W-1:0] uart_irq,
  output logic                      fdc_en,
  output logic [IO_AW-1:0]          fdc_base,
  output logic                      ide_en,
  output logic [IO_AW-1:0]          ide_base,
  output logic [IO_AW-1:0]          ide_alt_base
);

  localparam logic [IO_AW-1:0] IDE_ALT_OFS = 16'h0206;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg.pwr[7:4], cfg.pwr[2:0], cfg.fen[4]};

  assign par_en = cfg.fen[0];

  always_comb begin
    case (cfg.fadr[1:0])
      2'd0: begin par_base = 16'h0378; par_irq = cfg.pwr[3] ? 4'd7 : 4'd5; end
      2'd1: begin par_base = 16'h03BC; par_irq = 4'd7; end
      2'd2: begin par_base = 16'h0278; par_irq = 4'd5; end
      default: begin par_base = '0; par_irq = '0; end
    endcase
  end

  for (genvar u = 0; u < NUM_UART; u++) begin : g_uart
    assign uart_en[u] = cfg.fen[1+u];
    sio_uart_map u_map (
      .sel_code (cfg.fadr[2*u+3 -: 2]),
      .bank     (cfg.fadr[7:6]),
      .base     (uart_base[u*IO_AW +: IO_AW]),
      .irq      (uart_irq[u*IRQ_W +: IRQ_W])
    );
  end

  assign fdc_en       = cfg.fen[3];
  assign fdc_base     = cfg.fen[5] ? 16'h0370 : 16'h03F0;
  assign ide_en       = cfg.fen[6];
  assign ide_base     = cfg.fen[7] ? 16'h0170 : 16'h01F0;
  assign ide_alt_base = ide_base + IDE_ALT_OFS;

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h0398
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [4:0]   strap_cfg,
  input  logic [15:0]  io_addr,
  input  logic         io_wr,
  input  logic         io_rd,
  input  logic [7:0]   io_wdata,
  output logic [7:0]   io_rdata,
  output logic         par_en,
  output logic [15:0]  par_base,
  output logic [3:0]   par_irq,
  output logic [1:0]   uart_en,
  output logic [31:0]  uart_base,
  output logic [7:0]   uart_irq,
  output logic         fdc_en,
  output logic [15:0]  fdc_base,
  output logic [3:0]   fdc_irq,
  output logic         ide_en,
  output logic [15:0]  ide_base,
  output logic [15:0]  ide_alt_base,
  output logic [3:0]   ide_irq
);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             port_hit;
  logic             idx_wr, dat_wr, idx_rd, dat_rd;
  cfg_regs_t        cfg_q;
  logic [REG_W-1:0] sel_idx;
  sig_step_e        id_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign port_hit = (io_addr[IO_AW-1:1] == BASE_ADDR[IO_AW-1:1]);
  assign idx_wr   = io_wr & port_hit & ~io_addr[0];
  assign dat_wr   = io_wr & port_hit &  io_addr[0];
  assign idx_rd   = io_rd & port_hit & ~io_addr[0];
  assign dat_rd   = io_rd & port_hit &  io_addr[0];

  sio_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .strap_cfg (strap_cfg),
    .idx_wr    (idx_wr),
    .dat_wr    (dat_wr),
    .idx_rd    (idx_rd),
    .dat_rd    (dat_rd),
    .wdata     (io_wdata),
    .rdata     (io_rdata),
    .cfg_q     (cfg_q),
    .sel_q     (sel_idx),
    .step_q    (id_step)
  );

  sio_cfg_decode u_dec (
    .cfg          (cfg_q),
    .par_en       (par_en),
    .par_base     (par_base),
    .par_irq      (par_irq),
    .uart_en      (uart_en),
    .uart_base    (uart_base),
    .uart_irq     (uart_irq),
    .fdc_en       (fdc_en),
    .fdc_base     (fdc_base),
    .ide_en       (ide_en),
    .ide_base     (ide_base),
    .ide_alt_base (ide_alt_base)
  );

  assign fdc_irq = FDC_IRQ_NUM;
  assign ide_irq = IDE_IRQ_NUM;

endmodule

// File: rtl/sio_cfg_chk.sv
module sio_cfg_chk
  import sio_cfg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             idx_wr,
  input logic             dat_wr,
  input logic             idx_rd,
  input logic             dat_rd,
  input logic [REG_W-1:0] io_wdata,
  input logic [REG_W-1:0] io_rdata,
  input cfg_regs_t        cfg_q,
  input logic [REG_W-1:0] sel_idx,
  input sig_step_e        id_step,
  input logic [7:0]       uart_irq
);

  logic rd_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_prev <= 1'b0;
    else        rd_prev <= idx_rd;
  end

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(idx_rd || dat_rd) |-> io_rdata == '0);  // R1

  AST_IDX_WR_ENDS_SIG: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (id_step == SIG_OVER) && (sel_idx == $past(io_wdata)));  // R2

  AST_HELD_STROBE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_rd && rd_prev && !idx_wr) |=> $stable(id_step));  // R3

  AST_BAD_IDX_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && sel_idx >= REG_W'(NUM_REGS)) |-> io_rdata == '0);  // R5

  AST_BAD_IDX_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && sel_idx >= REG_W'(NUM_REGS)) |=> $stable(cfg_q));  // R5

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.pwr[LOCK_BIT] |=> cfg_q.pwr[LOCK_BIT]);  // R6

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.pwr[LOCK_BIT] |=> $stable(cfg_q));  // R6

  AST_UART_IRQ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_irq[3:0] == 4'd3 || uart_irq[3:0] == 4'd4) &&
    (uart_irq[7:4] == 4'd3 || uart_irq[7:4] == 4'd4));  // R10

endmodule

bind sio_cfg_port sio_cfg_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .idx_wr   (idx_wr),
  .dat_wr   (dat_wr),
  .idx_rd   (idx_rd),
  .dat_rd   (dat_rd),
  .io_wdata (io_wdata),
  .io_rdata (io_rdata),
  .cfg_q    (cfg_q),
  .sel_idx  (sel_idx),
  .id_step  (id_step),
  .uart_irq (uart_irq)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb_top;

  localparam logic [15:0] IDX_A = 16'h0398;
  localparam logic [15:0] DAT_A = 16'h0399;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  strap_cfg = 5'd1;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        par_en;
  logic [15:0] par_base;
  logic [3:0]  par_irq;
  logic [1:0]  uart_en;
  logic [31:0] uart_base;
  logic [7:0]  uart_irq;
  logic        fdc_en;
  logic [15:0] fdc_base;
  logic [3:0]  fdc_irq;
  logic        ide_en;
  logic [15:0] ide_base;
  logic [15:0] ide_alt_base;
  logic [3:0]  ide_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sio_cfg_port dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [4:0] s);
    @(negedge clk);
    rst_n = 1'b0;
    strap_cfg = s;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  function automatic logic [15:0] m_uart_base(input logic [7:0] f, input int n);
    logic [1:0] c = f[2*n+2 +: 2];
    logic [1:0] b = f[7:6];
    if (c == 2'd0) return 16'h03F8;
    if (c == 2'd1) return 16'h02F8;
    if (c == 2'd2) return (b == 0) ? 16'h03E8 : (b == 1) ? 16'h0338 : (b == 2) ? 16'h02E8 : 16'h0220;
    return (b == 0) ? 16'h02E8 : (b == 1) ? 16'h0238 : (b == 2) ? 16'h02E0 : 16'h0228;
  endfunction

  function automatic logic [15:0] m_par_base(input logic [7:0] f);
    case (f[1:0])
      2'd0: return 16'h0378;
      2'd1: return 16'h03BC;
      2'd2: return 16'h0278;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [3:0] m_par_irq(input logic [7:0] f, input bit p3);
    case (f[1:0])
      2'd0: return p3 ? 4'd7 : 4'd5;
      2'd1: return 4'd7;
      2'd2: return 4'd5;
      default: return 4'd0;
    endcase
  endfunction

  task automatic t_reset_strap1;
    logic [7:0] d;
    do_reset(5'd1);
    chk("R1 idle rdata", io_rdata, 8'h00);
    bus_rd(IDX_A, d); chk("R2 first sig", d, 8'h88);
    bus_rd(IDX_A, d); chk("R2 second sig", d, 8'h00);
    bus_rd(IDX_A, d); chk("R4 reset index", d, 8'h00);
    bus_rd(DAT_A, d); chk("R4 fen strap1", d, 8'h4F);
    bus_wr(IDX_A, 8'd1);
    bus_rd(DAT_A, d); chk("R4 fadr strap1", d, 8'h11);
    bus_wr(IDX_A, 8'd2);
    bus_rd(DAT_A, d); chk("R4 pwr strap1", d, 8'h00);
    bus_rd(IDX_A, d); chk("R2 index readback", d, 8'h02);
    chk("R7 enables", {par_en, uart_en, fdc_en, ide_en}, 5'b1_11_1_1);
    chk("R8 par base", par_base, 16'h03BC);
    chk("R8 par irq", par_irq, 4'd7);
    chk("R9 uart0 base", uart_base[15:0], 16'h03F8);
    chk("R9 uart1 base", uart_base[31:16], 16'h02F8);
    chk("R10 uart irqs", uart_irq, 8'h34);
    chk("R11 fdc", {fdc_base, fdc_irq}, {16'h03F0, 4'd6});
    chk("R11 ide", {ide_base, ide_alt_base, ide_irq}, {16'h01F0, 16'h03F6, 4'd14});
  endtask

  task automatic t_sig_cut;
    logic [7:0] d;
    do_reset(5'd1);
    bus_wr(IDX_A, 8'd1);
    bus_rd(IDX_A, d); chk("R2 write ends sig", d, 8'h01);
  endtask

  task automatic t_held_strobe;
    logic [7:0] d;
    do_reset(5'd1);
    @(negedge clk);
    io_addr = IDX_A; io_rd = 1'b1;
    #1 chk("R3 held first cycle", io_rdata, 8'h88);
    @(negedge clk);
    #1 chk("R3 held later cycle", io_rdata, 8'h00);
    repeat (2) @(negedge clk);
    io_rd = 1'b0;
    bus_rd(IDX_A, d); chk("R3 one step per strobe", d, 8'h00);
    bus_rd(IDX_A, d); chk("R3 then index", d, 8'h00);
  endtask

  task automatic t_addr_decode;
    logic [7:0] d;
    do_reset(5'd1);
    bus_wr(16'h039A, 8'd1);
    bus_wr(16'h039B, 8'h00);
    bus_wr(16'h0399 ^ 16'h1000, 8'h00);
    bus_rd(16'h039A, d); chk("R1 foreign read", d, 8'h00);
    bus_rd(DAT_A, d); chk("R1 fen untouched", d, 8'h4F);
    bus_rd(IDX_A, d); chk("R1 index untouched", d, 8'h88);
  endtask

  task automatic t_bad_index;
    logic [7:0] d;
    do_reset(5'd1);
    bus_wr(IDX_A, 8'd7);
    bus_wr(DAT_A, 8'hAA);
    bus_rd(DAT_A, d); chk("R5 bad index read", d, 8'h00);
    bus_wr(IDX_A, 8'd3);
    bus_wr(DAT_A, 8'hAA);
    bus_rd(DAT_A, d); chk("R5 index 3 read", d, 8'h00);
    bus_wr(IDX_A, 8'd0); bus_rd(DAT_A, d); chk("R5 fen kept", d, 8'h4F);
    bus_wr(IDX_A, 8'd1); bus_rd(DAT_A, d); chk("R5 fadr kept", d, 8'h11);
    bus_wr(IDX_A, 8'd2); bus_rd(DAT_A, d); chk("R5 pwr kept", d, 8'h00);
  endtask

  task automatic t_fen_decode;
    do_reset(5'd1);
    bus_wr(IDX_A, 8'd0);
    bus_wr(DAT_A, 8'hA5);
    chk("R7 enables A5", {par_en, uart_en, fdc_en, ide_en}, 5'b1_10_0_0);
    chk("R11 alt bases A5", {fdc_base, ide_base, ide_alt_base}, {16'h0370, 16'h0170, 16'h0376});
    bus_wr(DAT_A, 8'h5A);
    chk("R7 enables 5A", {par_en, uart_en, fdc_en, ide_en}, 5'b0_01_1_1);
    chk("R11 std bases 5A", {fdc_base, ide_base, ide_alt_base}, {16'h03F0, 16'h01F0, 16'h03F6});
  endtask

  task automatic t_fadr_sweep;
    do_reset(5'd1);
    bus_wr(IDX_A, 8'd1);
    for (int v = 0; v < 256; v++) begin
      bus_wr(DAT_A, 8'(v));
      chk("R8 par base sweep", par_base, m_par_base(8'(v)));
      chk("R8 par irq sweep", par_irq, m_par_irq(8'(v), 1'b0));
      chk("R9 uart0 sweep", uart_base[15:0], m_uart_base(8'(v), 0));
      chk("R9 uart1 sweep", uart_base[31:16], m_uart_base(8'(v), 1));
      chk("R10 uart0 irq", uart_irq[3:0], v[2] ? 4'd3 : 4'd4);
      chk("R10 uart1 irq", uart_irq[7:4], v[4] ? 4'd3 : 4'd4);
    end
    bus_wr(IDX_A, 8'd2); bus_wr(DAT_A, 8'h08);
    bus_wr(IDX_A, 8'd1); bus_wr(DAT_A, 8'h00);
    chk("R8 code0 irq7", par_irq, 4'd7);
    bus_wr(DAT_A, 8'h02);
    chk("R8 code2 ignores bit3", par_irq, 4'd5);
  endtask

  task automatic t_lock;
    logic [7:0] d;
    do_reset(5'd1);
    bus_wr(IDX_A, 8'd2); bus_wr(DAT_A, 8'h40);
    bus_wr(IDX_A, 8'd0); bus_wr(DAT_A, 8'h00);
    bus_rd(DAT_A, d); chk("R6 fen frozen", d, 8'h4F);
    chk("R6 par_en held", par_en, 1'b1);
    bus_wr(IDX_A, 8'd1); bus_wr(DAT_A, 8'hFF);
    bus_rd(DAT_A, d); chk("R6 fadr frozen", d, 8'h11);
    bus_wr(IDX_A, 8'd2); bus_wr(DAT_A, 8'h00);
    bus_rd(DAT_A, d); chk("R6 lock sticky", d, 8'h40);
    do_reset(5'd1);
    bus_wr(IDX_A, 8'd0); bus_wr(DAT_A, 8'h00);
    bus_rd(DAT_A, d); chk("R6 reset unlocks", d, 8'h00);
  endtask

  task automatic t_other_straps;
    logic [7:0] d;
    do_reset(5'd12);
    bus_rd(DAT_A, d); chk("R4 fen strap12", d, 8'h0F);
    bus_wr(IDX_A, 8'd1); bus_rd(DAT_A, d); chk("R4 fadr strap12", d, 8'h10);
    do_reset(5'd31);
    bus_rd(DAT_A, d); chk("R4 fen strap31", d, 8'h00);
    bus_wr(IDX_A, 8'd1); bus_rd(DAT_A, d); chk("R4 fadr strap31", d, 8'h10);
    bus_wr(IDX_A, 8'd2); bus_rd(DAT_A, d); chk("R4 pwr strap31", d, 8'h02);
  endtask

  initial begin
    t_reset_strap1();
    t_sig_cut();
    t_held_strobe();
    t_addr_decode();
    t_bad_index();
    t_fen_decode();
    t_fadr_sweep();
    t_lock();
    t_other_straps();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule